// File: doc/BRIEF.md
# Multichannel Complex Weighted Beam Combiner

The block forms one or more receive beams from the baseband I/Q samples of a group of array channels that are sampled together. On every clock it can take one new sample set: one complex sample per channel. Each channel's sample is multiplied by a complex steering weight. The products of all channels are then added coherently, and the sum is scaled back to the output width. The result is one beam sample per beam per accepted input set.

Each beam has its own weight table. The table holds one complex weight per channel for every beam direction. A per-beam direction index picks the row, and the index travels with the sample set it arrives with. Because of this, pointing can change on any sample without blending two directions. Weights are loaded through a simple write port. The number of beams formed at once is a parameter. Every beam shares the same input samples and repeats the multiply-and-sum path with its own table.

The datapath has one register after the input and one after the complex multiply. It then has one register per adder-tree level and one after rounding. This gives a fixed latency of 3 + clog2(NCH) clocks, which is 5 with the defaults.

Top module: `beam_combiner`

## Requirements
- R1: For each beam, the output equals round(sum over channels of x_c * w_c / 2^SHIFT) for both components. Here x_c and w_c are the complex input sample and weight: real part = xr*wr - xi*wi, imaginary part = xr*wi + xi*wr.
- R2: A write with `wt_we` high stores (`wt_re`, `wt_im`) for beam `wt_beam`, direction `wt_dir`, channel `wt_ch`. A sample set presented on any later cycle uses the stored value.
- R3: A new sample set is accepted on every clock with `in_valid` high. Back-to-back sets each produce their own output, with no stall.
- R4: `out_valid` equals `in_valid` delayed by exactly LAT = 3 + clog2(NCH) clocks, so input gaps show up as identical output gaps.
- R5: Rounding adds 2^(SHIFT-1) and then shifts arithmetically right by SHIFT. Halves therefore go toward plus infinity: 1.5 gives 2 and -1.5 gives -1.
- R6: Each component that falls outside the signed OW-bit range is clamped to 2^(OW-1)-1 or -2^(OW-1).
- R7: `ovf[b]` rises after a valid output of beam b saturated in either component. It then stays high until reset, and it stays low while no valid output saturates.
- R8: Each beam uses only its own table and its own direction field `beam_dir[b*DIRW +: DIRW]`. Two beams given the same weights and direction produce the same output.
- R9: Each sample set is weighted wholly with the weight row of the direction index presented in the same cycle. A direction change between consecutive sets never mixes rows.
- R10: While reset is held and right after it, `out_valid` and every `ovf` bit are 0.
- R11: Weights are WW-bit signed values where 2^SHIFT means unity; the defaults are WW=18 and SHIFT=16. Samples are IW-bit signed, up to 27 bits. With unity weights on all channels and the same input on every channel, the output is NCH times the input.
- R12: With steering weights w_c = exp(-j*c*phi_d) and a plane wave x_c = A*exp(j*c*phi_m), the output magnitude is largest when d = m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample set is valid |
| in_re | input | NCH*IW | Real parts, channel c at bits c*IW +: IW |
| in_im | input | NCH*IW | Imaginary parts, same layout |
| beam_dir | input | NBEAM*clog2(DIRS) | Direction index per beam |
| wt_we | input | 1 | Weight write strobe |
| wt_beam | input | max(1,clog2(NBEAM)) | Beam of the weight write |
| wt_dir | input | clog2(DIRS) | Direction row of the weight write |
| wt_ch | input | max(1,clog2(NCH)) | Channel of the weight write |
| wt_re | input | WW | Weight real part |
| wt_im | input | WW | Weight imaginary part |
| out_valid | output | 1 | Output beam samples valid |
| out_re | output | NBEAM*OW | Beam real parts, beam b at bits b*OW +: OW |
| out_im | output | NBEAM*OW | Beam imaginary parts |
| ovf | output | NBEAM | Sticky saturation flag per beam |

## Verification
The bench changes direction indices at random on every sample. If the direction were taken from a different cycle than the data, the outputs would drift by one row. Random gaps in `in_valid` expose a valid pipeline that is one stage short or long, or that fills gaps with stale data. A weight is written and then used on the very next sample, which catches a table that updates late. Directed cases target the rounding halves on both sides of zero and clamping at both rails. They also check that the sticky flag sets on saturation and holds afterwards. A plane-wave sweep across all directions confirms the phase sign convention: a conjugation error would move the peak to the wrong row.

// File: rtl/bf_pkg.sv
package bf_pkg;

  // Index width that never collapses to zero bits.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Round half toward +inf, then arithmetic right shift.
  function automatic logic signed [63:0] round_shr(input logic signed [63:0] v, input int sh);
    logic signed [63:0] half;
    half = 64'sd1 <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // True when v does not fit a signed w-bit field.
  function automatic logic beyond(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    return (v > hi) || (v < lo);
  endfunction

endpackage

// File: rtl/bf_weight_bank.sv
module bf_weight_bank
  import bf_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DIRS = 8,
  parameter int WW   = 18,
  parameter int DIRW = 3,
  parameter int CW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DIRW-1:0]   wdir,
  input  logic [CW-1:0]     wch,
  input  logic [WW-1:0]     wre,
  input  logic [WW-1:0]     wim,
  input  logic [DIRW-1:0]   rdir,
  output logic [NCH*WW-1:0] w_re_q,
  output logic [NCH*WW-1:0] w_im_q
);
  localparam int DEPTH = DIRS * NCH;
  localparam int AW    = idx_w(DEPTH);

  logic [2*WW-1:0] mem [DEPTH];
  logic [AW-1:0]   waddr;

  assign waddr = AW'(int'(wdir) * NCH + int'(wch));

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wre, wim};
  end

  // Whole row captured together with the sample set of the same cycle.
  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      w_re_q[c*WW +: WW] <= mem[AW'(int'(rdir) * NCH + c)][2*WW-1:WW];
      w_im_q[c*WW +: WW] <= mem[AW'(int'(rdir) * NCH + c)][WW-1:0];
    end
  end

  AST_WT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(we) && $stable(rdir)) |=> ($stable(w_re_q) && $stable(w_im_q)))
    else $error("weight row changed without write or direction change"); // R9

endmodule

// File: rtl/bf_cmult.sv
module bf_cmult #(
  parameter int IW = 16,
  parameter int WW = 18,
  parameter int PW = 35
) (
  input  logic                 clk,
  input  logic signed [IW-1:0] x_re,
  input  logic signed [IW-1:0] x_im,
  input  logic signed [WW-1:0] w_re,
  input  logic signed [WW-1:0] w_im,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im
);
  logic signed [IW+WW-1:0] m_rr, m_ii, m_ri, m_ir;

  assign m_rr = x_re * w_re;
  assign m_ii = x_im * w_im;
  assign m_ri = x_re * w_im;
  assign m_ir = x_im * w_re;

  always_ff @(posedge clk) begin
    p_re <= PW'(m_rr) - PW'(m_ii);
    p_im <= PW'(m_ri) + PW'(m_ir);
  end

endmodule

// File: rtl/bf_adder_tree.sv
module bf_adder_tree #(
  parameter int NIN = 4,
  parameter int DW  = 35,
  parameter int LV  = 2
) (
  input  logic                     clk,
  input  logic [NIN*DW-1:0]        din,
  output logic signed [DW+LV-1:0]  dout
);
  localparam int SW = DW + LV;
  localparam int P  = 1 << LV;

  for (genvar k = 0; k <= LV; k++) begin : g_lv
    logic signed [SW-1:0] v [P >> k];
    if (k == 0) begin : g_leaf
      for (genvar i = 0; i < P; i++) begin : g_in
        if (i < NIN) begin : g_use
          assign v[i] = SW'(signed'(din[i*DW +: DW]));
        end else begin : g_pad
          assign v[i] = '0;
        end
      end
    end else begin : g_sum
      for (genvar i = 0; i < (P >> k); i++) begin : g_add
        always_ff @(posedge clk) v[i] <= g_lv[k-1].v[2*i] + g_lv[k-1].v[2*i+1];
      end
    end
  end

  assign dout = g_lv[LV].v[0];

endmodule

// File: rtl/bf_round_sat.sv
module bf_round_sat
  import bf_pkg::*;
#(
  parameter int SW    = 37,
  parameter int OW    = 16,
  parameter int SHIFT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic signed [SW-1:0] s_re,
  input  logic signed [SW-1:0] s_im,
  output logic signed [OW-1:0] o_re,
  output logic signed [OW-1:0] o_im,
  output logic                 ovf
);
  localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};

  logic signed [63:0] r_re, r_im;
  logic sat_re_hit, sat_im_hit, sat_hit;

  assign r_re       = round_shr(64'(s_re), SHIFT);
  assign r_im       = round_shr(64'(s_im), SHIFT);
  assign sat_re_hit = beyond(r_re, OW);
  assign sat_im_hit = beyond(r_im, OW);
  assign sat_hit    = sat_re_hit || sat_im_hit;

  function automatic logic signed [OW-1:0] clamp(input logic signed [63:0] v, input logic hit);
    if (!hit) return OW'(v);
    return (v < 0) ? MINV : MAXV;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_re <= '0;
      o_im <= '0;
      ovf  <= 1'b0;
    end else begin
      o_re <= clamp(r_re, sat_re_hit);
      o_im <= clamp(r_im, sat_im_hit);
      if (v_in && sat_hit) ovf <= 1'b1;
    end
  end

  AST_SAT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    sat_re_hit |=> (o_re == MAXV || o_re == MINV))
    else $error("saturated real part not at a rail"); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && sat_hit) |=> ovf)
    else $error("saturation did not raise flag"); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf)
    else $error("overflow flag dropped"); // R7
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !(v_in && sat_hit)) |=> !ovf)
    else $error("overflow flag rose without saturation"); // R7

endmodule

// File: rtl/beam_combiner.sv
module beam_combiner
  import bf_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NBEAM = 2,
  parameter int DIRS  = 8,
  parameter int IW    = 16,
  parameter int WW    = 18,
  parameter int OW    = 16,
  parameter int SHIFT = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [NCH*IW-1:0]                  in_re,
  input  logic [NCH*IW-1:0]                  in_im,
  input  logic [NBEAM*$clog2(DIRS)-1:0]      beam_dir,
  input  logic                               wt_we,
  input  logic [bf_pkg::idx_w(NBEAM)-1:0]    wt_beam,
  input  logic [$clog2(DIRS)-1:0]            wt_dir,
  input  logic [bf_pkg::idx_w(NCH)-1:0]      wt_ch,
  input  logic [WW-1:0]                      wt_re,
  input  logic [WW-1:0]                      wt_im,
  output logic                               out_valid,
  output logic [NBEAM*OW-1:0]                out_re,
  output logic [NBEAM*OW-1:0]                out_im,
  output logic [NBEAM-1:0]                   ovf
);
  localparam int DIRW = $clog2(DIRS);
  localparam int BW   = idx_w(NBEAM);
  localparam int CW   = idx_w(NCH);
  localparam int LV   = $clog2(NCH);
  localparam int PW   = IW + WW + 1;
  localparam int SW   = PW + LV;
  localparam int LAT  = 3 + LV;

  logic [LAT-1:0]    vld;
  logic [NCH*IW-1:0] x_re_q, x_im_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    x_re_q <= in_re;
    x_im_q <= in_im;
  end

  assign out_valid = vld[LAT-1];

  for (genvar b = 0; b < NBEAM; b++) begin : g_beam
    logic [NCH*WW-1:0] w_re, w_im;
    logic [NCH*PW-1:0] p_re, p_im;
    logic [SW-1:0]     s_re, s_im;
    logic              wsel;

    assign wsel = wt_we && (wt_beam == BW'(b));

    bf_weight_bank #(.NCH(NCH), .DIRS(DIRS), .WW(WW), .DIRW(DIRW), .CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wsel), .wdir(wt_dir), .wch(wt_ch),
      .wre(wt_re), .wim(wt_im), .rdir(beam_dir[b*DIRW +: DIRW]),
      .w_re_q(w_re), .w_im_q(w_im));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
      bf_cmult #(.IW(IW), .WW(WW), .PW(PW)) u_mul (
        .clk(clk),
        .x_re(x_re_q[c*IW +: IW]), .x_im(x_im_q[c*IW +: IW]),
        .w_re(w_re[c*WW +: WW]),   .w_im(w_im[c*WW +: WW]),
        .p_re(p_re[c*PW +: PW]),   .p_im(p_im[c*PW +: PW]));
    end

    bf_adder_tree #(.NIN(NCH), .DW(PW), .LV(LV)) u_tre (.clk(clk), .din(p_re), .dout(s_re));
    bf_adder_tree #(.NIN(NCH), .DW(PW), .LV(LV)) u_tim (.clk(clk), .din(p_im), .dout(s_im));

    bf_round_sat #(.SW(SW), .OW(OW), .SHIFT(SHIFT)) u_rs (
      .clk(clk), .rst_n(rst_n), .v_in(vld[LAT-2]),
      .s_re(s_re), .s_im(s_im),
      .o_re(out_re[b*OW +: OW]), .o_im(out_im[b*OW +: OW]), .ovf(ovf[b]));
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, LAT))
    else $error("output valid not aligned to input valid"); // R4

endmodule

// File: tb/test_beam_combiner.sv
module test_beam_combiner;
  localparam int NCH = 4, NB = 2, ND = 8, IW = 16, WW = 18, OW = 16;
  localparam int LAT = 5; // input reg, product reg, two tree levels, output reg

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [NCH*IW-1:0] in_re = '0, in_im = '0;
  logic [NB*3-1:0] beam_dir = '0;
  logic wt_we = 1'b0;
  logic [0:0] wt_beam = '0;
  logic [2:0] wt_dir = '0;
  logic [1:0] wt_ch = '0;
  logic [WW-1:0] wt_re = '0, wt_im = '0;
  logic out_valid;
  logic [NB*OW-1:0] out_re, out_im;
  logic [NB-1:0] ovf;

  beam_combiner i_beam_combiner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .beam_dir(beam_dir), .wt_we(wt_we), .wt_beam(wt_beam), .wt_dir(wt_dir), .wt_ch(wt_ch),
    .wt_re(wt_re), .wt_im(wt_im), .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
    .ovf(ovf));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int mw_re [NB][ND][NCH];
  int mw_im [NB][ND][NCH];
  int n_re [NCH], n_im [NCH], n_dir [NB];
  int n_wb, n_wd, n_wc, n_wre, n_wim;
  bit n_valid = 0, n_we = 0;
  bit [LAT-1:0] hist = '0;
  int q_re [$], q_im [$];
  bit q_sat [$];
  bit stk [NB];
  int obs_re [NB], obs_im [NB];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rsat(input longint v, output bit s);
    longint r;
    r = (v + 64'sd32768) >>> 16;
    s = 0;
    if (r > 32767) begin r = 32767; s = 1; end
    else if (r < -32768) begin r = -32768; s = 1; end
    return int'(r);
  endfunction

  task automatic check_outputs();
    chk(out_valid == hist[LAT-1], "R4 out_valid timing", int'(out_valid), int'(hist[LAT-1]));
    if (out_valid && q_re.size() >= NB) begin
      for (int b = 0; b < NB; b++) begin
        int er, ei; bit es;
        er = q_re.pop_front(); ei = q_im.pop_front(); es = q_sat.pop_front();
        obs_re[b] = int'($signed(out_re[b*OW +: OW]));
        obs_im[b] = int'($signed(out_im[b*OW +: OW]));
        chk(obs_re[b] == er, {tag, " real"}, obs_re[b], er);
        chk(obs_im[b] == ei, {tag, " imag"}, obs_im[b], ei);
        if (es) stk[b] = 1;
      end
    end
    for (int b = 0; b < NB; b++)
      chk(ovf[b] == stk[b], "R7 sticky flag", int'(ovf[b]), int'(stk[b]));
  endtask

  task automatic apply();
    for (int c = 0; c < NCH; c++) begin
      in_re[c*IW +: IW] = IW'(n_re[c]);
      in_im[c*IW +: IW] = IW'(n_im[c]);
    end
    for (int b = 0; b < NB; b++) beam_dir[b*3 +: 3] = 3'(n_dir[b]);
    in_valid = n_valid;
    wt_we = n_we; wt_beam = 1'(n_wb); wt_dir = 3'(n_wd); wt_ch = 2'(n_wc);
    wt_re = WW'(n_wre); wt_im = WW'(n_wim);
    if (n_valid) begin
      for (int b = 0; b < NB; b++) begin
        longint sr, si; bit s1, s2; int d;
        sr = 0; si = 0; d = n_dir[b];
        for (int c = 0; c < NCH; c++) begin
          sr += longint'(n_re[c]) * mw_re[b][d][c] - longint'(n_im[c]) * mw_im[b][d][c];
          si += longint'(n_re[c]) * mw_im[b][d][c] + longint'(n_im[c]) * mw_re[b][d][c];
        end
        q_re.push_back(rsat(sr, s1));
        q_im.push_back(rsat(si, s2));
        q_sat.push_back(s1 | s2);
      end
    end
    if (n_we) begin
      mw_re[n_wb][n_wd][n_wc] = n_wre;
      mw_im[n_wb][n_wd][n_wc] = n_wim;
    end
    hist = {hist[LAT-2:0], n_valid};
  endtask

  task automatic cycle();
    @(negedge clk);
    check_outputs();
    apply();
  endtask

  task automatic wr(input int b, input int d, input int c, input int re, input int im);
    n_valid = 0; n_we = 1; n_wb = b; n_wd = d; n_wc = c; n_wre = re; n_wim = im;
    cycle();
    n_we = 0;
  endtask

  task automatic idle(input int n);
    n_valid = 0;
    repeat (n) cycle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; wt_we = 0; n_valid = 0; n_we = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10 out_valid in reset", int'(out_valid), 0);
    chk(ovf == '0, "R10 ovf in reset", int'(ovf), 0);
    rst_n = 1;
    hist = '0; q_re.delete(); q_im.delete(); q_sat.delete();
    for (int b = 0; b < NB; b++) stk[b] = 0;
  endtask

  task automatic set_all(input int re, input int im);
    for (int c = 0; c < NCH; c++) begin n_re[c] = re; n_im[c] = im; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    real phi [ND];
    longint mag [ND];
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) for (int d = 0; d < ND; d++) for (int c = 0; c < NCH; c++) begin
      mw_re[b][d][c] = 0; mw_im[b][d][c] = 0;
    end
    set_all(0, 0);
    for (int b = 0; b < NB; b++) n_dir[b] = 0;
    do_reset();

    // Zero every table entry so the model matches from the start.
    for (int b = 0; b < NB; b++) for (int d = 0; d < ND; d++) for (int c = 0; c < NCH; c++)
      wr(b, d, c, 0, 0);

    // R11: unity weights, identical inputs -> NCH times input.
    tag = "R11 uniform";
    for (int b = 0; b < NB; b++) for (int c = 0; c < NCH; c++) wr(b, 2, c, 65536, 0);
    n_dir[0] = 2; n_dir[1] = 2; set_all(5000, -3000); n_valid = 1; cycle();
    idle(LAT);
    chk(obs_re[0] == 20000, "R11 N times input real", obs_re[0], 20000);
    chk(obs_im[1] == -12000, "R11 N times input imag", obs_im[1], -12000);

    // R6/R7: saturation at both rails and sticky flag.
    tag = "R6 saturation";
    set_all(30000, -30000); n_valid = 1; cycle();
    idle(LAT);
    chk(obs_re[0] == 32767, "R6 upper rail", obs_re[0], 32767);
    chk(obs_im[0] == -32768, "R6 lower rail", obs_im[0], -32768);
    chk(ovf == 2'b11, "R7 flag set", int'(ovf), 3);
    set_all(10, 10); n_valid = 1; cycle(); idle(LAT);
    chk(ovf == 2'b11, "R7 flag holds", int'(ovf), 3);
    do_reset();

    // R5: rounding of halves on both sides of zero (weight 0.5 on channel 0 only).
    tag = "R5 rounding";
    wr(0, 0, 0, 32768, 0);
    n_dir[0] = 0; n_dir[1] = 0; set_all(0, 0); n_re[0] = 3; n_valid = 1; cycle();
    idle(LAT);
    chk(obs_re[0] == 2, "R5 plus half", obs_re[0], 2);
    n_re[0] = -3; n_valid = 1; cycle(); idle(LAT);
    chk(obs_re[0] == -1, "R5 minus half", obs_re[0], -1);

    // R2: write then use on the very next sample.
    tag = "R2 write then use";
    wr(1, 1, 3, 0, 65536);
    n_dir[1] = 1; set_all(0, 0); n_re[3] = 1234; n_valid = 1; cycle(); idle(LAT);
    chk(obs_im[1] == 1234, "R2 new weight used", obs_im[1], 1234);

    // R12: plane-wave sweep; beam0 sweeps direction, beam1 stays matched (R8).
    tag = "R12 steering";
    for (int d = 0; d < ND; d++) phi[d] = 3.14159265358979 * $sin((d - 4) * 20.0 * 3.14159265358979 / 180.0);
    for (int b = 0; b < NB; b++) for (int d = 0; d < ND; d++) for (int c = 0; c < NCH; c++)
      wr(b, d, c, $rtoi($floor(16384.0 * $cos(-c * phi[d]) + 0.5)),
                  $rtoi($floor(16384.0 * $sin(-c * phi[d]) + 0.5)));
    for (int c = 0; c < NCH; c++) begin
      n_re[c] = $rtoi($floor(8000.0 * $cos(c * phi[5]) + 0.5));
      n_im[c] = $rtoi($floor(8000.0 * $sin(c * phi[5]) + 0.5));
    end
    for (int d = 0; d < ND; d++) begin
      n_dir[0] = d; n_dir[1] = 5; n_valid = 1; cycle(); idle(LAT);
      mag[d] = longint'(obs_re[0]) * obs_re[0] + longint'(obs_im[0]) * obs_im[0];
      chk(obs_re[1] == obs_re[0] || d != 5, "R8 beams agree", obs_re[1], obs_re[0]);
    end
    for (int d = 0; d < ND; d++)
      if (d != 5) chk(mag[5] > mag[d], "R12 matched peak", int'(mag[5] >>> 8), int'(mag[d] >>> 8));

    // R1 R3 R8 R9: random weights, random data, direction per sample, gaps (R4).
    for (int b = 0; b < NB; b++) for (int d = 0; d < ND; d++) for (int c = 0; c < NCH; c++)
      wr(b, d, c, int'($signed(18'($urandom))) >>> 2, int'($signed(18'($urandom))) >>> 2);
    tag = "R1 R3 R8 R9 random";
    for (int i = 0; i < 3000; i++) begin
      n_valid = (i < 500) ? 1'b1 : ($urandom_range(3) != 0);
      for (int c = 0; c < NCH; c++) begin
        n_re[c] = int'($signed(16'($urandom)));
        n_im[c] = int'($signed(16'($urandom)));
      end
      for (int b = 0; b < NB; b++) n_dir[b] = $urandom_range(ND - 1);
      cycle();
    end
    idle(LAT + 2);

    do_reset();
    idle(LAT + 1);
    chk(ovf == '0, "R10 flag cleared by reset", int'(ovf), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule